// File: doc/BRIEF.md
# Double-Buffered Byte DMA Descriptor Engine

This block sits between a byte-serial bus master and a simple single-port memory. It holds one buffer descriptor for transmit and one for receive. Each descriptor is a start address and a maximum byte count. Software writes these into shadow registers. A start command copies the shadows into working registers. Because of this, the shadows can be reloaded for the following transfer while the current one is still moving bytes.

On the transmit side, the block fetches each byte from memory before the serial engine asks for it. The engine finds a byte already waiting when it begins shifting. On the receive side, each byte from the engine is held and then written to consecutive addresses. For each direction the block reports a running count of the bytes actually moved. It raises pulse events for:
- a transfer having started,
- the last byte being reached,
- a stop that has fully drained the memory port.

Top module: `dbdma_desc_engine`

## Requirements
- R1: A start pulse copies the shadow pointer and shadow count of its direction into the working registers. The matching started output pulses high for exactly the cycle after the start.
- R2: Shadow writes made after the started pulse do not change the running transfer. The next start of that direction uses the rewritten values.
- R3: During transmit, the block reads memory at pointer, pointer+1, and so on, exactly count times. tx_byte_vld rises only after the read has completed, and tx_byte then holds the read data until it is taken.
- R4: During receive, each accepted byte is written with mem_we=1 to consecutive addresses starting at the pointer. mem_wdata carries the byte.
- R5: A start clears the amount of its own direction and leaves the other direction's amount unchanged. Each byte moved adds one. The value is held after the transfer stops.
- R6: last_tx pulses once per transfer, in the cycle after the final byte is taken. At that point tx_amount equals the count.
- R7: last_rx pulses once when the final byte is next to be received. This is the cycle after the start if the count is 1; otherwise it is the cycle after the second-to-last byte is written. At that point rx_amount equals count-1.
- R8: Receive bytes that arrive after count bytes have been accepted are ignored. They cause no memory write and no change to rx_amount.
- R9: After stop_req, stopped pulses only once no memory access is pending. mem_req is low when stopped pulses, and it stays low until the next started pulse.
- R10: Once mem_req is raised, it and mem_addr stay stable until a cycle with mem_ack high.
- R11: After reset, mem_req, tx_byte_vld, all event outputs and both amounts are zero.
- R12: A transfer with count 0 performs no memory access and raises no last event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_sel | input | 2 | Shadow select: 0 tx pointer, 1 tx count, 2 rx pointer, 3 rx count |
| cfg_wdata | input | AW | Shadow write data (count uses the low CW bits) |
| start_tx | input | 1 | Start a transmit transfer |
| start_rx | input | 1 | Start a receive transfer |
| stop_req | input | 1 | Request the engine to stop |
| tx_byte | output | DW | Prefetched transmit byte |
| tx_byte_vld | output | 1 | tx_byte holds a byte ready to send |
| tx_byte_take | input | 1 | Serial engine begins shifting tx_byte |
| rx_byte | input | DW | Byte received by the serial engine |
| rx_byte_vld | input | 1 | rx_byte is valid this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Access completes this cycle |
| tx_started | output | 1 | Transmit descriptor latched |
| rx_started | output | 1 | Receive descriptor latched |
| last_tx | output | 1 | Final transmit byte taken |
| last_rx | output | 1 | Final receive byte is next |
| stopped | output | 1 | Stop complete, memory port quiet |
| tx_amount | output | CW | Bytes sent in the latest transmit transfer |
| rx_amount | output | CW | Bytes stored in the latest receive transfer |

## Verification
A corrupted working pointer appears on mem_addr at the very next access. It shows up as a transmitted byte that differs from the memory image, or as a receive byte landing at the wrong address. A working count that is off by one is caught at the end of the transfer. It yields an extra or missing read, a misplaced last event, or an amount that disagrees with the count. A shadow that leaks into a running transfer shows within one byte time after the started pulse. A stop that fires too early is seen in the same cycle as stopped, because mem_req is still high then.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

  // shadow register select codes
  localparam logic [1:0] SEL_TX_PTR = 2'd0;
  localparam logic [1:0] SEL_TX_CNT = 2'd1;
  localparam logic [1:0] SEL_RX_PTR = 2'd2;
  localparam logic [1:0] SEL_RX_CNT = 2'd3;

  localparam int unsigned NDIR   = 2;
  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;

  typedef enum logic [1:0] {
    MP_IDLE  = 2'd0,
    MP_READ  = 2'd1,
    MP_WRITE = 2'd2
  } mport_st_e;

endpackage

// File: rtl/dbdma_chan.sv
module dbdma_chan #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic          cnt_we,
  input  logic [AW-1:0] wdata,
  input  logic          load,
  input  logic          step,
  output logic [CW-1:0] shadow_cnt,
  output logic [AW-1:0] work_ptr,
  output logic [CW-1:0] work_left,
  output logic [CW-1:0] amount
);

  logic [AW-1:0] sh_ptr_q, sh_ptr_d;
  logic [CW-1:0] sh_cnt_q, sh_cnt_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] left_q, left_d;
  logic [CW-1:0] amt_q, amt_d;
  logic          work_en;

  assign work_en = load | step;

  always_comb begin
    sh_ptr_d = wdata;
    sh_cnt_d = wdata[CW-1:0];
    ptr_d    = ptr_q;
    left_d   = left_q;
    amt_d    = amt_q;
    if (load) begin
      ptr_d  = sh_ptr_q;
      left_d = sh_cnt_q;
      amt_d  = '0;
    end else if (step) begin
      ptr_d  = ptr_q + AW'(1);
      left_d = left_q - CW'(1);
      amt_d  = amt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ptr_q <= '0;
      sh_cnt_q <= '0;
      ptr_q    <= '0;
      left_q   <= '0;
      amt_q    <= '0;
    end else begin
      if (ptr_we)  sh_ptr_q <= sh_ptr_d;
      if (cnt_we)  sh_cnt_q <= sh_cnt_d;
      if (work_en) begin
        ptr_q  <= ptr_d;
        left_q <= left_d;
        amt_q  <= amt_d;
      end
    end
  end

  assign shadow_cnt = sh_cnt_q;
  assign work_ptr   = ptr_q;
  assign work_left  = left_q;
  assign amount     = amt_q;

  assert_step_within_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |-> left_q != '0);

  assert_load_copies_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == $past(sh_ptr_q)) && (left_q == $past(sh_cnt_q)));

  assert_amount_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> amt_q == '0);

  assert_amount_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> amt_q == $past(amt_q) + CW'(1));

endmodule

// File: rtl/dbdma_mport.sv
module dbdma_mport
  import dbdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic          wr_issue,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          idle,
  output logic          rd_done,
  output logic          wr_done,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  mport_st_e     st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          cap_en;

  assign idle = (st_q == MP_IDLE);
  assign cap_en = idle & (rd_issue | wr_issue);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    unique case (st_q)
      MP_IDLE: begin
        if (wr_issue) begin
          st_d   = MP_WRITE;
          addr_d = wr_addr;
          wd_d   = wr_data;
        end else if (rd_issue) begin
          st_d   = MP_READ;
          addr_d = rd_addr;
        end
      end
      MP_READ, MP_WRITE: begin
        if (mem_ack) st_d = MP_IDLE;
      end
      default: st_d = MP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MP_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        addr_q <= addr_d;
        wd_q   <= wd_d;
      end
    end
  end

  assign mem_req   = (st_q != MP_IDLE);
  assign mem_we    = (st_q == MP_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign rd_done   = (st_q == MP_READ) & mem_ack;
  assign wr_done   = (st_q == MP_WRITE) & mem_ack;
  assign rd_data   = mem_rdata;

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

endmodule

// File: rtl/dbdma_desc_engine.sv
module dbdma_desc_engine
  import dbdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic          stop_req,
  output logic [DW-1:0] tx_byte,
  output logic          tx_byte_vld,
  input  logic          tx_byte_take,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_byte_vld,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          tx_started,
  output logic          rx_started,
  output logic          last_tx,
  output logic          last_rx,
  output logic          stopped,
  output logic [CW-1:0] tx_amount,
  output logic [CW-1:0] rx_amount
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  // per-direction descriptor signals
  logic [NDIR-1:0] ch_ptr_we, ch_cnt_we, ch_load, ch_step;
  logic [AW-1:0]   ch_ptr    [NDIR];
  logic [CW-1:0]   ch_left   [NDIR];
  logic [CW-1:0]   ch_amt    [NDIR];
  logic [CW-1:0]   ch_sh_cnt [NDIR];

  // control state
  logic          tx_act_q, tx_act_d;
  logic          rx_act_q, rx_act_d;
  logic          stop_pend_q, stop_pend_d;
  logic [DW-1:0] txbuf_q, txbuf_d;
  logic          txbuf_vld_q, txbuf_vld_d;
  logic [DW-1:0] rxhold_q, rxhold_d;
  logic          rxhold_vld_q, rxhold_vld_d;
  logic          ev_txs_q, ev_rxs_q, ev_ltx_q, ev_lrx_q, ev_stop_q;
  logic          ev_ltx_d, ev_lrx_d;

  // memory port handshake
  logic          mp_idle, rd_issue, wr_issue, rd_done, wr_done;
  logic [DW-1:0] rd_data;
  logic          take_ok, rx_accept, stop_fire;

  assign ch_load[DIR_TX] = start_tx;
  assign ch_load[DIR_RX] = start_rx;
  assign ch_step[DIR_TX] = take_ok;
  assign ch_step[DIR_RX] = wr_done;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign ch_ptr_we[d] = cfg_we && (cfg_sel == 2'(2 * d));
    assign ch_cnt_we[d] = cfg_we && (cfg_sel == 2'(2 * d + 1));

    dbdma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ptr_we     (ch_ptr_we[d]),
      .cnt_we     (ch_cnt_we[d]),
      .wdata      (cfg_wdata),
      .load       (ch_load[d]),
      .step       (ch_step[d]),
      .shadow_cnt (ch_sh_cnt[d]),
      .work_ptr   (ch_ptr[d]),
      .work_left  (ch_left[d]),
      .amount     (ch_amt[d])
    );
  end

  // byte movement conditions
  assign take_ok   = tx_byte_take & txbuf_vld_q;
  assign rx_accept = rx_byte_vld & rx_act_q & ~rxhold_vld_q & (ch_left[DIR_RX] != '0);
  assign rd_issue  = tx_act_q & ~stop_pend_q & ~txbuf_vld_q & (ch_left[DIR_TX] != '0)
                   & mp_idle & ~start_tx & ~start_rx;
  assign wr_issue  = rx_act_q & rxhold_vld_q & mp_idle;
  assign stop_fire = stop_pend_q & mp_idle & ~rxhold_vld_q;

  dbdma_mport #(.AW(AW), .DW(DW)) u_mport (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issue  (rd_issue),
    .wr_issue  (wr_issue),
    .rd_addr   (ch_ptr[DIR_TX]),
    .wr_addr   (ch_ptr[DIR_RX]),
    .wr_data   (rxhold_q),
    .idle      (mp_idle),
    .rd_done   (rd_done),
    .wr_done   (wr_done),
    .rd_data   (rd_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  always_comb begin
    tx_act_d     = tx_act_q;
    rx_act_d     = rx_act_q;
    stop_pend_d  = stop_pend_q;
    txbuf_d      = txbuf_q;
    txbuf_vld_d  = txbuf_vld_q;
    rxhold_d     = rxhold_q;
    rxhold_vld_d = rxhold_vld_q;
    if (rd_done) begin
      txbuf_d     = rd_data;
      txbuf_vld_d = tx_act_q;
    end
    if (take_ok) txbuf_vld_d = 1'b0;
    if (rx_accept) begin
      rxhold_d     = rx_byte;
      rxhold_vld_d = 1'b1;
    end
    if (wr_done) rxhold_vld_d = 1'b0;
    if (stop_req) stop_pend_d = 1'b1;
    if (stop_fire) begin
      stop_pend_d = 1'b0;
      tx_act_d    = 1'b0;
      rx_act_d    = 1'b0;
      txbuf_vld_d = 1'b0;
    end
    if (start_tx) begin
      tx_act_d    = 1'b1;
      rx_act_d    = 1'b0;
      txbuf_vld_d = 1'b0;
    end
    if (start_rx) begin
      rx_act_d = 1'b1;
      tx_act_d = 1'b0;
    end
  end

  assign ev_ltx_d = take_ok & (ch_left[DIR_TX] == ONE);
  assign ev_lrx_d = (start_rx & (ch_sh_cnt[DIR_RX] == ONE))
                  | (wr_done & (ch_left[DIR_RX] == TWO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act_q     <= 1'b0;
      rx_act_q     <= 1'b0;
      stop_pend_q  <= 1'b0;
      txbuf_q      <= '0;
      txbuf_vld_q  <= 1'b0;
      rxhold_q     <= '0;
      rxhold_vld_q <= 1'b0;
      ev_txs_q     <= 1'b0;
      ev_rxs_q     <= 1'b0;
      ev_ltx_q     <= 1'b0;
      ev_lrx_q     <= 1'b0;
      ev_stop_q    <= 1'b0;
    end else begin
      tx_act_q     <= tx_act_d;
      rx_act_q     <= rx_act_d;
      stop_pend_q  <= stop_pend_d;
      txbuf_vld_q  <= txbuf_vld_d;
      rxhold_vld_q <= rxhold_vld_d;
      if (rd_done)   txbuf_q  <= txbuf_d;
      if (rx_accept) rxhold_q <= rxhold_d;
      ev_txs_q     <= start_tx;
      ev_rxs_q     <= start_rx;
      ev_ltx_q     <= ev_ltx_d;
      ev_lrx_q     <= ev_lrx_d;
      ev_stop_q    <= stop_fire;
    end
  end

  assign tx_byte     = txbuf_q;
  assign tx_byte_vld = txbuf_vld_q;
  assign tx_started  = ev_txs_q;
  assign rx_started  = ev_rxs_q;
  assign last_tx     = ev_ltx_q;
  assign last_rx     = ev_lrx_q;
  assign stopped     = ev_stop_q;
  assign tx_amount   = ch_amt[DIR_TX];
  assign rx_amount   = ch_amt[DIR_RX];

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !mem_req);

  assert_txbyte_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_vld && !tx_byte_take && !start_tx && !start_rx && !stop_pend_q
    |=> tx_byte_vld && $stable(tx_byte));

  assert_last_tx_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && (ch_left[DIR_TX] == ONE) && !start_tx |=> last_tx && (tx_amount != '0));

  assert_rx_write_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |-> ch_left[DIR_RX] != '0);

endmodule

// File: tb/dbdma_desc_engine_bench.sv
module dbdma_desc_engine_bench;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          start_tx, start_rx, stop_req;
  logic [DW-1:0] tx_byte;
  logic          tx_byte_vld, tx_byte_take;
  logic [DW-1:0] rx_byte;
  logic          rx_byte_vld;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_ack;
  logic          tx_started, rx_started, last_tx, last_rx, stopped;
  logic [CW-1:0] tx_amount, rx_amount;

  dbdma_desc_engine #(.AW(AW), .CW(CW), .DW(DW)) u_dbdma_desc_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start_tx(start_tx), .start_rx(start_rx), .stop_req(stop_req),
    .tx_byte(tx_byte), .tx_byte_vld(tx_byte_vld), .tx_byte_take(tx_byte_take),
    .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_started(tx_started), .rx_started(rx_started), .last_tx(last_tx),
    .last_rx(last_rx), .stopped(stopped), .tx_amount(tx_amount), .rx_amount(rx_amount)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic [7:0] rd_log  [256];
  int rd_cnt = 0, wr_cnt = 0, lat = 0;
  int n_txs = 0, n_rxs = 0, n_ltx = 0, n_lrx = 0, n_stop = 0;
  int ltx_amt = 0, lrx_amt = 0;
  bit quiet = 0;
  bit hold_prev = 0;
  logic [AW-1:0] addr_prev;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // memory responder with random latency; also watches request stability (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        n_tests++;
        if (!mem_req || mem_addr != addr_prev) begin
          n_fail++;
          $display("FAIL R10 actual=%0d expected=%0d", mem_addr, addr_prev);
        end
      end
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat == 0) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr[7:0]] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem[mem_addr[7:0]];
            rd_log[rd_cnt % 256] = mem_addr[7:0];
            rd_cnt++;
          end
          lat = $urandom_range(0, 3);
        end else lat--;
      end
      hold_prev = mem_req && !mem_ack;
      addr_prev = mem_addr;
    end
  end

  // event monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_started || rx_started) quiet = 0;
      if (tx_started) n_txs++;
      if (rx_started) n_rxs++;
      if (last_tx) begin n_ltx++; ltx_amt = int'(tx_amount); end
      if (last_rx) begin n_lrx++; lrx_amt = int'(rx_amount); end
      if (stopped) begin
        n_stop++;
        chk(!mem_req, "R9 mem_req at stopped", int'(mem_req), 0);
        quiet = 1;
      end else if (quiet && mem_req) begin
        chk(1'b0, "R9 request after stop", 1, 0);
        quiet = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = AW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic stop_and_wait();
    int s0 = n_stop;
    int w = 0;
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    while (n_stop == s0 && w < 60) begin @(negedge clk); w++; end
    chk(n_stop == s0 + 1, "R9 stopped seen", n_stop - s0, 1);
  endtask

  // transmit: optionally load shadows, optionally rewrite them right after started (R2)
  task automatic do_tx(input int ptr, input int cnt, input bit load_sh,
                       input bit rw, input int nptr, input int ncnt);
    int rb, l0;
    if (load_sh) begin
      cfg_write(2'd0, ptr);
      cfg_write(2'd1, cnt);
    end
    rb = rd_cnt; l0 = n_ltx;
    @(negedge clk); start_tx = 1'b1;
    @(negedge clk); start_tx = 1'b0;
    chk(tx_started == 1'b1, "R1 tx_started", int'(tx_started), 1);
    chk(tx_amount == 0, "R5 tx_amount cleared", int'(tx_amount), 0);
    if (rw) begin
      cfg_write(2'd0, nptr);
      cfg_write(2'd1, ncnt);
    end
    for (int i = 0; i < cnt; i++) begin
      int w = 0;
      while (!tx_byte_vld && w < 60) begin @(negedge clk); w++; end
      chk(tx_byte == mem[(ptr + i) % 256], rw ? "R2 byte under rewrite" : "R3 tx byte",
          int'(tx_byte), int'(mem[(ptr + i) % 256]));
      tx_byte_take = 1'b1;
      @(negedge clk);
      tx_byte_take = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk(!tx_byte_vld, "R3 no byte beyond count", int'(tx_byte_vld), 0);
    chk(rd_cnt - rb == cnt, cnt == 0 ? "R12 no read on zero count" : "R3 read count",
        rd_cnt - rb, cnt);
    for (int i = 0; i < cnt; i++)
      chk(int'(rd_log[(rb + i) % 256]) == (ptr + i) % 256, "R3 read address",
          int'(rd_log[(rb + i) % 256]), (ptr + i) % 256);
    stop_and_wait();
    chk(int'(tx_amount) == cnt, "R5 tx_amount", int'(tx_amount), cnt);
    chk(n_ltx - l0 == (cnt > 0 ? 1 : 0), cnt == 0 ? "R12 no last_tx" : "R6 last_tx once",
        n_ltx - l0, cnt > 0 ? 1 : 0);
    if (cnt > 0) chk(ltx_amt == cnt, "R6 amount at last_tx", ltx_amt, cnt);
  endtask

  task automatic do_rx(input int ptr, input int cnt, input int nb);
    int wb, l0, moved, exp_l;
    logic [7:0] b;
    bit ok4, ok8;
    cfg_write(2'd2, ptr);
    cfg_write(2'd3, cnt);
    for (int j = 0; j < 256; j++) exp_mem[j] = mem[j];
    wb = wr_cnt; l0 = n_lrx;
    @(negedge clk); start_rx = 1'b1;
    @(negedge clk); start_rx = 1'b0;
    chk(rx_started == 1'b1, "R1 rx_started", int'(rx_started), 1);
    chk(rx_amount == 0, "R5 rx_amount cleared", int'(rx_amount), 0);
    for (int i = 0; i < nb; i++) begin
      repeat (10) @(negedge clk);
      b = 8'($urandom);
      rx_byte = b; rx_byte_vld = 1'b1;
      @(negedge clk);
      rx_byte_vld = 1'b0;
      if (i < cnt) exp_mem[(ptr + i) % 256] = b;
    end
    repeat (10) @(negedge clk);
    stop_and_wait();
    moved = (nb < cnt) ? nb : cnt;
    chk(int'(rx_amount) == moved, "R5 rx_amount", int'(rx_amount), moved);
    chk(wr_cnt - wb == moved, cnt == 0 ? "R12 no write on zero count" : "R4 write count",
        wr_cnt - wb, moved);
    ok4 = 1; ok8 = 1;
    for (int j = 0; j < 256; j++) begin
      if (mem[j] != exp_mem[j]) begin
        if (((j - ptr + 256) % 256) < cnt) ok4 = 0; else ok8 = 0;
      end
    end
    chk(ok4, "R4 rx data in memory", int'(ok4), 1);
    chk(ok8, "R8 overflow bytes ignored", int'(ok8), 1);
    exp_l = (cnt == 1 || (cnt >= 2 && nb >= cnt - 1)) ? 1 : 0;
    chk(n_lrx - l0 == exp_l, cnt == 0 ? "R12 no last_rx" : "R7 last_rx count",
        n_lrx - l0, exp_l);
    if (exp_l == 1) chk(lrx_amt == cnt - 1, "R7 amount at last_rx", lrx_amt, cnt - 1);
  endtask

  initial begin
    int keep;
    void'($urandom(32'd4242));
    for (int j = 0; j < 256; j++) mem[j] = 8'((j * 37 + 5) % 256);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    start_tx = 1'b0; start_rx = 1'b0; stop_req = 1'b0; tx_byte_take = 1'b0;
    rx_byte = '0; rx_byte_vld = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!mem_req, "R11 mem_req", int'(mem_req), 0);
    chk(!tx_byte_vld, "R11 tx_byte_vld", int'(tx_byte_vld), 0);
    chk({tx_started, rx_started, last_tx, last_rx, stopped} == 5'b0, "R11 events",
        int'({tx_started, rx_started, last_tx, last_rx, stopped}), 0);
    chk(tx_amount == 0 && rx_amount == 0, "R11 amounts", int'(tx_amount) + int'(rx_amount), 0);

    // directed: tx with shadow rewrite after started, then next tx takes new values (R2)
    do_tx(10, 4, 1'b1, 1'b1, 60, 3);
    do_tx(60, 3, 1'b0, 1'b0, 0, 0);
    // zero count and single byte
    do_tx(20, 0, 1'b1, 1'b0, 0, 0);
    do_tx(30, 1, 1'b1, 1'b0, 0, 0);
    keep = int'(tx_amount);
    // rx: single byte, overflow, short, exact
    do_rx(100, 1, 1);
    chk(int'(tx_amount) == keep, "R5 tx_amount kept across rx", int'(tx_amount), keep);
    do_rx(110, 3, 5);
    do_rx(130, 4, 2);
    do_rx(140, 0, 2);
    do_rx(150, 5, 5);

    // constrained random
    for (int k = 0; k < 10; k++) begin
      int p = $urandom_range(0, 200);
      int c = $urandom_range(0, 6);
      if ($urandom_range(0, 1) == 0) do_tx(p, c, 1'b1, 1'b0, 0, 0);
      else do_rx(p, c, c + $urandom_range(0, 2));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule